// File: doc/BRIEF.md
# Power-Up Reset and Clock Settling Sequencer

This block orders the start-up of a DSP-style device. Three active-low reset levels come in. The power-on reset (`init_rst_n`) is the deepest of them. It holds the whole block and its control registers at their default values. A release of the power-on reset turns on the reference and clock-generator enable and starts a settling wait, which is measured in pulses of a free-running reference tick. The wait is long in bit-clock mode 3 and short in every other clock mode. Until the wait has run out, the clock output stays disabled and every host command is refused, whether it is a register write, a program word or a run control. When the wait ends, `clkout_en` and `ready` rise together.

The clock reset (`clk_rst_n`) can be asserted at any time. It drops the clock output and the command gate, and a full settling wait starts again after its release. The control register contents are kept through it. The system reset (`sys_rst_n`) closes the command gate and halts the DSP run state, but it does not touch the settling timer. During power-on, the clock reset may either be tied to the power-on reset or held high, and both arrangements give the same sequence. `sys_rst_n`, `clk_rst_n`, `ref_tick`, `clk_mode` and the command inputs are synchronous to `clk`. The power-on reset acts asynchronously.

Host commands arrive on one valid/ready stream. A transfer happens on a clock edge where `cmd_valid` and `cmd_ready` are both high. Program words go out on a second valid/ready stream (`prog_valid`/`prog_ready`). For a program word, `cmd_ready` follows `prog_ready`, so downstream back-pressure stalls the host. For every other operation, `cmd_ready` equals `ready`.

Top module: `pwrup_seq_ctrl`

## Requirements
- R1: While `init_rst_n` is low, every control register reads `REG_DEFAULT` (0x5A), and `gen_en`, `clkout_en`, `ready` and `dsp_run` are all low.
- R2: After `clk_rst_n` and `init_rst_n` are both high, `gen_en` goes high on the first clock edge and starts the settling wait. The `clk_mode` value seen on that edge selects the wait length.
- R3: For `clk_mode` values other than 4 (0 is crystal, 1 to 3 are bit-clock modes 0 to 2), `clkout_en` rises on the clock edge that samples the `SHORT_TICKS`-th `ref_tick` pulse of the wait, and not earlier.
- R4: For `clk_mode` = 4 (bit-clock mode 3), `clkout_en` rises on the edge that samples the `LONG_TICKS`-th `ref_tick` pulse.
- R5: A change of `clk_mode` after the wait has started does not change the length of that wait.
- R6: Before `clkout_en` is high, `cmd_ready` and `prog_valid` stay low and the register contents do not change.
- R7: `ready` rises on the same edge as `clkout_en` whenever `sys_rst_n` is high.
- R8: A low `clk_rst_n` clears `clkout_en`, `ready` and `gen_en` on the next edge and keeps the register contents. After its release, a complete new wait runs.
- R9: A low `sys_rst_n` clears `ready` and `dsp_run` on the next edge and leaves `clkout_en` high. After its release, `ready` returns on the next edge with no new wait.
- R10: Program words (`cmd_op` = 1) reach `prog_data` unchanged and in the order they were sent. Under back-pressure from `prog_ready` none is lost or repeated.
- R11: An accepted register write (`cmd_op` = 0) loads `cmd_data` into the register that `cmd_addr` selects. Register i occupies bits [8i+7:8i] of `ctrl_regs`. An accepted `cmd_op` = 2 sets `dsp_run`, and an accepted `cmd_op` = 3 clears it.
- R12: Holding `clk_rst_n` high while `init_rst_n` is low gives the same start-up sequence as tying the two together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| init_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low |
| clk_rst_n | input | 1 | Clock reset, active low |
| ref_tick | input | 1 | Reference tick pulse that paces the settling wait |
| clk_mode | input | 3 | Clock mode select: 0 crystal, 1-3 bit-clock 0-2, 4 bit-clock 3 |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Host command accepted this edge |
| cmd_op | input | 2 | 0 register write, 1 program word, 2 run, 3 halt |
| cmd_addr | input | AW | Register index for a write |
| cmd_data | input | DW | Register value or program word |
| prog_valid | output | 1 | Program word valid |
| prog_ready | input | 1 | Program sink ready |
| prog_data | output | DW | Program word |
| gen_en | output | 1 | Reference and clock-generator enable |
| clkout_en | output | 1 | Clock output enable |
| ready | output | 1 | Command gate open |
| dsp_run | output | 1 | DSP run state |
| ctrl_regs | output | NREG*DW | Control register contents, flattened |

## Verification
The assertions take the reset levels and `ref_tick` to be synchronous to `clk`. They also take `ref_tick` to be a single-cycle pulse and the host to hold a command stable until it is accepted. The bench drives every input one time unit after a rising edge, so each input is a clean synchronous level. Tick pulses are always one cycle wide with a low cycle between them. Commands are held until `cmd_ready` is seen at a falling edge. Settling lengths are shortened through parameters so that both wait lengths can be counted pulse by pulse.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_LOCKED = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_REG_WR = 2'd0,
    OP_PROG   = 2'd1,
    OP_RUN    = 2'd2,
    OP_HALT   = 2'd3
  } cmd_op_e;

  // clock mode that needs the long settling wait
  localparam logic [2:0] MODE_SLOW_LOCK = 3'd4;
endpackage

// File: rtl/settle_timer.sv
module settle_timer
  import pwrseq_pkg::*;
#(
  parameter int SHORT_TICKS = 50,
  parameter int LONG_TICKS  = 175,
  parameter int MODE_W      = 3
) (
  input  logic              clk,
  input  logic              init_rst_n,
  input  logic              clk_rst_n,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  output logic              gen_en,
  output logic              locked,
  output logic              lock_next
);
  localparam int MAXT = (SHORT_TICKS > LONG_TICKS) ? SHORT_TICKS : LONG_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;
  logic [CW-1:0] last_cnt;

  assign last_cnt = long_q ? LONG_LAST : SHORT_LAST;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    long_d  = long_q;
    if (!clk_rst_n) begin
      state_d = SQ_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          state_d = SQ_SETTLE;
          cnt_d   = '0;
          long_d  = (mode == MODE_W'(MODE_SLOW_LOCK));
        end
        SQ_SETTLE: begin
          if (tick) begin
            if (cnt_q == last_cnt) state_d = SQ_LOCKED;
            else                   cnt_d   = cnt_q + 1'b1;
          end
        end
        SQ_LOCKED: ;
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge init_rst_n) begin
    if (!init_rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      long_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      long_q  <= long_d;
    end
  end

  assign gen_en    = (state_q != SQ_IDLE);
  assign locked    = (state_q == SQ_LOCKED);
  assign lock_next = (state_d == SQ_LOCKED);

  // R3: the tick count never passes the selected limit
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!init_rst_n)
    (state_q == SQ_SETTLE) |-> (cnt_q <= last_cnt));
  // R3: lock is only reached on a sampled tick
  a_r3_lock_on_tick: assert property (@(posedge clk) disable iff (!init_rst_n)
    $rose(locked) |-> $past(tick));
  // R5: the chosen wait length stays fixed during a wait
  a_r5_mode_held: assert property (@(posedge clk) disable iff (!init_rst_n)
    (state_q == SQ_SETTLE) |=> (state_q != SQ_SETTLE) || $stable(long_q));
  // R8: clock reset drops enable and lock
  a_r8_clkrst_drop: assert property (@(posedge clk) disable iff (!init_rst_n)
    !clk_rst_n |=> (!locked && !gen_en));
  // R9: lock persists while clock reset is idle
  a_r9_lock_kept: assert property (@(posedge clk) disable iff (!init_rst_n)
    (locked && clk_rst_n) |=> locked);
endmodule

// File: rtl/cmd_gate.sv
module cmd_gate
  import pwrseq_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          init_rst_n,
  input  logic          sys_rst_n,
  input  logic          lock_next,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          cmd_ready,
  output logic          prog_valid,
  input  logic          prog_ready,
  output logic [DW-1:0] prog_data,
  output logic          ready,
  output logic          run,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  cmd_op_e op;
  logic    gate_q;
  logic    run_q;
  logic    accept;

  assign op = cmd_op_e'(cmd_op);

  always_ff @(posedge clk or negedge init_rst_n) begin
    if (!init_rst_n) gate_q <= 1'b0;
    else             gate_q <= lock_next && sys_rst_n;
  end

  assign cmd_ready  = gate_q && ((op != OP_PROG) || prog_ready);
  assign accept     = cmd_valid && cmd_ready;
  assign prog_valid = cmd_valid && gate_q && (op == OP_PROG);
  assign prog_data  = cmd_data;
  assign wr_en      = accept && (op == OP_REG_WR);
  assign wr_addr    = cmd_addr;
  assign wr_data    = cmd_data;

  always_ff @(posedge clk or negedge init_rst_n) begin
    if (!init_rst_n)                    run_q <= 1'b0;
    else if (!sys_rst_n)                run_q <= 1'b0;
    else if (accept && op == OP_RUN)    run_q <= 1'b1;
    else if (accept && op == OP_HALT)   run_q <= 1'b0;
  end

  assign ready = gate_q;
  assign run   = run_q;

  // R6: no program word leaves while the gate is shut
  a_r6_prog_gated: assert property (@(posedge clk) disable iff (!init_rst_n)
    prog_valid |-> ready);
  // R9: system reset shuts the gate and halts the run state
  a_r9_sysrst_close: assert property (@(posedge clk) disable iff (!init_rst_n)
    !sys_rst_n |=> (!ready && !run));
  // R10: an accepted program word is a completed downstream transfer
  a_r10_prog_xfer: assert property (@(posedge clk) disable iff (!init_rst_n)
    (cmd_valid && cmd_ready && cmd_op == 2'd1) |-> (prog_valid && prog_ready));
endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int            NREG        = 4,
  parameter int            DW          = 8,
  parameter int            AW          = 2,
  parameter logic [DW-1:0] REG_DEFAULT = 'h5A
) (
  input  logic             clk,
  input  logic             init_rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [NREG*DW-1:0] regs_o
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] val_q;
    always_ff @(posedge clk or negedge init_rst_n) begin
      if (!init_rst_n)                         val_q <= REG_DEFAULT;
      else if (wr_en && wr_addr == AW'(i))     val_q <= wr_data;
    end
    assign regs_o[i*DW +: DW] = val_q;
  end

  // R11: contents change only through an accepted write
  a_r11_hold: assert property (@(posedge clk) disable iff (!init_rst_n)
    !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int SHORT_TICKS = 50,
  parameter int LONG_TICKS  = 175,
  parameter int NREG        = 4,
  parameter int DW          = 8,
  parameter logic [DW-1:0] REG_DEFAULT = 'h5A,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              init_rst_n,
  input  logic              sys_rst_n,
  input  logic              clk_rst_n,
  input  logic              ref_tick,
  input  logic [2:0]        clk_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [DW-1:0]     cmd_data,
  output logic              prog_valid,
  input  logic              prog_ready,
  output logic [DW-1:0]     prog_data,
  output logic              gen_en,
  output logic              clkout_en,
  output logic              ready,
  output logic              dsp_run,
  output logic [NREG*DW-1:0] ctrl_regs
);
  logic          lock_next;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  settle_timer #(
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS),
    .MODE_W     (3)
  ) u_timer (
    .clk       (clk),
    .init_rst_n(init_rst_n),
    .clk_rst_n (clk_rst_n),
    .tick      (ref_tick),
    .mode      (clk_mode),
    .gen_en    (gen_en),
    .locked    (clkout_en),
    .lock_next (lock_next)
  );

  cmd_gate #(.DW(DW), .AW(AW)) u_gate (
    .clk       (clk),
    .init_rst_n(init_rst_n),
    .sys_rst_n (sys_rst_n),
    .lock_next (lock_next),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_ready (cmd_ready),
    .prog_valid(prog_valid),
    .prog_ready(prog_ready),
    .prog_data (prog_data),
    .ready     (ready),
    .run       (dsp_run),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  ctrl_regfile #(
    .NREG(NREG), .DW(DW), .AW(AW), .REG_DEFAULT(REG_DEFAULT)
  ) u_regs (
    .clk       (clk),
    .init_rst_n(init_rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .regs_o    (ctrl_regs)
  );

  // R6: no register write lands before the clock is settled
  a_r6_no_early_write: assert property (@(posedge clk) disable iff (!init_rst_n)
    wr_en |-> clkout_en);
  // R7: the command gate is never open without a settled clock
  a_r7_ready_locked: assert property (@(posedge clk) disable iff (!init_rst_n)
    ready |-> clkout_en);
  // R7: when the clock settles with system reset idle, the gate opens with it
  a_r7_same_edge: assert property (@(posedge clk) disable iff (!init_rst_n)
    ($rose(clkout_en) && $past(sys_rst_n)) |-> ready);
endmodule

// File: tb/pwrup_seq_ctrl_tb.sv
module pwrup_seq_ctrl_tb;
  localparam int SHORT = 4;
  localparam int LONG  = 7;
  localparam int NREG  = 4;
  localparam int DW    = 8;
  localparam logic [7:0] DEF = 8'h5A;

  logic clk = 1'b0;
  logic init_rst_n = 1'b0, sys_rst_n = 1'b0, clk_rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic [2:0] clk_mode = 3'd0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_addr = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic prog_valid;
  logic prog_ready = 1'b1;
  logic [7:0] prog_data;
  logic gen_en, clkout_en, ready, dsp_run;
  logic [NREG*DW-1:0] ctrl_regs;

  int checks = 0;
  int errors = 0;
  bit bp_on = 1'b0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  pwrup_seq_ctrl #(
    .SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .NREG(NREG), .DW(DW), .REG_DEFAULT(DEF)
  ) u_dut (
    .clk(clk), .init_rst_n(init_rst_n), .sys_rst_n(sys_rst_n), .clk_rst_n(clk_rst_n),
    .ref_tick(ref_tick), .clk_mode(clk_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .prog_valid(prog_valid), .prog_ready(prog_ready), .prog_data(prog_data),
    .gen_en(gen_en), .clkout_en(clkout_en), .ready(ready), .dsp_run(dsp_run),
    .ctrl_regs(ctrl_regs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick_pulse();
    @(posedge clk); #1 ref_tick = 1'b1;
    @(posedge clk); #1 ref_tick = 1'b0;
  endtask

  task automatic send_cmd(input logic [1:0] op, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    if (op == 2'd1) exp_q.push_back(d);
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #1 cmd_valid = 1'b0;
  endtask

  task automatic regs_all(input string req, input logic [7:0] v);
    for (int i = 0; i < NREG; i++) chk(req, ctrl_regs[i*8 +: 8], v);
  endtask

  // back-pressure pattern on the program sink
  initial begin
    int n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      prog_ready = bp_on ? ((n % 3) != 1) : 1'b1;
    end
  end

  // scoreboard monitor for program words
  always @(negedge clk) begin
    if (prog_valid && prog_ready) begin
      if (exp_q.size() == 0) chk("R10 unexpected word", {24'h0, prog_data}, 32'hFFFF_FFFF);
      else chk("R10 word order", {24'h0, prog_data}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
  end

  initial begin
    // R1: power-on state with clock reset tied to power-on reset
    repeat (3) @(posedge clk);
    @(negedge clk);
    regs_all("R1 default", DEF);
    chk("R1 gen_en", gen_en, 0);
    chk("R1 clkout_en", clkout_en, 0);
    chk("R1 ready", ready, 0);
    chk("R1 dsp_run", dsp_run, 0);

    // R2/R3/R6/R7: release both together, crystal mode
    @(posedge clk); #1;
    init_rst_n = 1'b1; clk_rst_n = 1'b1; sys_rst_n = 1'b1; clk_mode = 3'd0;
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 2'd1; cmd_data = 8'h33;
    tick_pulse();
    @(negedge clk);
    chk("R2 gen_en after release", gen_en, 1);
    chk("R6 cmd_ready while settling", cmd_ready, 0);
    for (int k = 0; k < SHORT - 2; k++) tick_pulse();
    @(negedge clk);
    chk("R3 clkout_en before last tick", clkout_en, 0);
    chk("R7 ready before last tick", ready, 0);
    chk("R6 cmd_ready before last tick", cmd_ready, 0);
    cmd_valid = 1'b0;
    tick_pulse();
    @(negedge clk);
    chk("R3 clkout_en on last tick", clkout_en, 1);
    chk("R7 ready with clkout_en", ready, 1);
    chk("R6 refused write left reg", ctrl_regs[15:8], DEF);

    // R11: register write and run control
    send_cmd(2'd0, 2'd2, 8'hC3);
    @(negedge clk);
    chk("R11 reg2 written", ctrl_regs[23:16], 8'hC3);
    chk("R11 reg1 untouched", ctrl_regs[15:8], DEF);
    send_cmd(2'd2, 2'd0, 8'h00);
    @(negedge clk);
    chk("R11 run set", dsp_run, 1);

    // R10: program words under back-pressure
    bp_on = 1'b1;
    for (int k = 0; k < 6; k++) send_cmd(2'd1, 2'd0, 8'h10 + 8'(k * 7));
    repeat (2) @(posedge clk);
    bp_on = 1'b0;
    chk("R10 all words delivered", exp_q.size(), 0);
    send_cmd(2'd3, 2'd0, 8'h00);
    @(negedge clk);
    chk("R11 run cleared by halt", dsp_run, 0);
    send_cmd(2'd2, 2'd0, 8'h00);

    // R9: system reset
    @(posedge clk); #1 sys_rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 ready low", ready, 0);
    chk("R9 run cleared", dsp_run, 0);
    chk("R9 clkout kept", clkout_en, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 clkout still kept", clkout_en, 1);
    chk("R9 regs kept", ctrl_regs[23:16], 8'hC3);
    @(posedge clk); #1 sys_rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R9 ready back", ready, 1);

    // R8/R4/R5: clock reset, then long mode with a mid-wait mode change
    @(posedge clk); #1 clk_rst_n = 1'b0; clk_mode = 3'd4;
    @(posedge clk); @(negedge clk);
    chk("R8 clkout low", clkout_en, 0);
    chk("R8 ready low", ready, 0);
    chk("R8 gen_en low", gen_en, 0);
    chk("R8 regs kept", ctrl_regs[23:16], 8'hC3);
    @(posedge clk); #1 clk_rst_n = 1'b1;
    tick_pulse();
    clk_mode = 3'd0;
    for (int k = 0; k < LONG - 2; k++) tick_pulse();
    @(negedge clk);
    chk("R5 short length not applied", clkout_en, 0);
    chk("R4 clkout before last long tick", clkout_en, 0);
    tick_pulse();
    @(negedge clk);
    chk("R4 clkout on last long tick", clkout_en, 1);
    chk("R8 ready after new wait", ready, 1);
    send_cmd(2'd2, 2'd0, 8'h00);

    // R12/R1: power-on reset with clock reset held high, bit-clock mode 1
    @(posedge clk); #1 init_rst_n = 1'b0;
    @(negedge clk);
    regs_all("R1 default again", DEF);
    chk("R1 run low", dsp_run, 0);
    chk("R1 clkout low", clkout_en, 0);
    clk_mode = 3'd2;
    @(posedge clk); #1 init_rst_n = 1'b1;
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_data = 8'hEE;
    for (int k = 0; k < SHORT - 1; k++) tick_pulse();
    @(negedge clk);
    chk("R6 no prog while settling", prog_valid, 0);
    chk("R12 clkout before last tick", clkout_en, 0);
    cmd_valid = 1'b0;
    tick_pulse();
    @(negedge clk);
    chk("R12 clkout on last tick", clkout_en, 1);
    chk("R12 ready with clkout", ready, 1);
    chk("R10 no stray words", exp_q.size(), 0);

    summary();
  end
endmodule